// File: doc/BRIEF.md
# AXI Error Response Interrupt Register

This block monitors the write-response and read-response channels of an AXI master port and notes every error response that completes a handshake. Each of four error kinds (slave error or decode error, on either channel) owns a sticky status bit. Software can read all of the block's state through one 32-bit register and can change it through the same register.

Each error kind has two separate gates. The first gate, a status-enable bit, decides whether a new event is recorded at all. The second gate, a signal-enable bit, decides whether a recorded status reaches the single level-sensitive interrupt output. Because of this split, software can poll an error kind without taking interrupts for it. Software can also stop new recordings and still keep the evidence already captured.

The interrupt output is registered, so it follows the status and signal-enable bits one clock later. Software acknowledges an event by writing 1 to its status bit.

Top module: `axi_err_irq_reg`

## Requirements
- R1: A response code of 2'b10 counts as a slave error and 2'b11 counts as a decode error. The status bits are laid out in the register as follows: bit 3 is write-response slave error, bit 2 is write-response decode error, bit 1 is read-response slave error and bit 0 is read-response decode error.
- R2: An error response counts only in a cycle where both valid and ready of its channel are 1. A response with valid or ready low has no effect on the register.
- R3: Response codes 2'b00 and 2'b01 never set a status bit.
- R4: A status bit is set only by an event that arrives while that source's status-enable bit is 1. An event that arrives while the bit is 0 is ignored.
- R5: The `irq` output is 1 in the cycle after any source has both its status bit and its signal-enable bit at 1. Otherwise `irq` is 0.
- R6: The status-enable bits sit at [11:8] and the signal-enable bits at [19:16], in the same source order as the status bits. Both groups take the written value. Bits [31:20], [15:12] and [7:4] always read 0, and writes to them have no effect.
- R7: Once set, a status bit stays at 1 until a write with a 1 in its position clears it. Writing 0 to a status bit leaves it unchanged.
- R8: If an enabled event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R9: Clearing a status-enable bit keeps that source's status bit as it was. The change only blocks later events.
- R10: During and after reset, all status, status-enable and signal-enable bits read 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational view of state |
| b_valid | input | 1 | Write-response valid |
| b_ready | input | 1 | Write-response ready |
| b_resp | input | 2 | Write-response code |
| r_valid | input | 1 | Read-response valid |
| r_ready | input | 1 | Read-response ready |
| r_resp | input | 2 | Read-response code |
| irq | output | 1 | Level interrupt |

## Verification
Two functions can land on the same status bit in one clock: an error event that sets the bit and a software write that clears it. The other collision is a status-enable change that arrives together with an event. The bench provokes both collisions in directed steps, then continues with several thousand cycles of random responses, codes and writes. In every cycle it compares the read value and `irq` against a behavioural model in which the set has priority and the status-enable value from before the write gates the event.

// File: rtl/axi_err_irq_reg.sv
module axi_err_irq_reg #(
  parameter int NSRC = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        b_valid,
  input  logic        b_ready,
  input  logic [1:0]  b_resp,
  input  logic        r_valid,
  input  logic        r_ready,
  input  logic [1:0]  r_resp,
  output logic        irq
);
  localparam int SEN_LSB = 8;
  localparam int SIG_LSB = 16;

  logic [NSRC-1:0] status_q, sen_q, sig_q, ev, clr;
  logic b_hs, r_hs, unused_wbits;

  assign b_hs = b_valid && b_ready && b_resp[1];
  assign r_hs = r_valid && r_ready && r_resp[1];
  assign ev   = {b_hs && !b_resp[0], b_hs && b_resp[0], r_hs && !r_resp[0], r_hs && r_resp[0]};
  assign clr  = reg_wr_en ? reg_wdata[NSRC-1:0] : '0;
  assign unused_wbits = ^{reg_wdata[31:SIG_LSB+NSRC], reg_wdata[SIG_LSB-1:SEN_LSB+NSRC],
                          reg_wdata[SEN_LSB-1:NSRC]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      sen_q    <= '0;
      sig_q    <= '0;
      irq      <= 1'b0;
    end else begin
      status_q <= (status_q & ~clr) | (ev & sen_q);
      irq      <= |(status_q & sig_q);
      if (reg_wr_en) begin
        sen_q <= reg_wdata[SEN_LSB +: NSRC];
        sig_q <= reg_wdata[SIG_LSB +: NSRC];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    reg_rdata[NSRC-1:0]          = status_q;
    reg_rdata[SEN_LSB +: NSRC]   = sen_q;
    reg_rdata[SIG_LSB +: NSRC]   = sig_q;
  end

  AST_SET_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & ~$past(status_q) & ~$past(sen_q)) == '0)); // R4
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr_en |=> ((status_q & $past(status_q)) == $past(status_q))); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(ev & sen_q)) == $past(ev & sen_q))); // R8
  AST_OK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr_en && !(r_valid && r_ready && r_resp[1]) && !(b_valid && b_ready && b_resp[1]))
      |=> $stable(status_q)); // R3
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & sig_q) == '0) |=> !irq); // R5
endmodule

// File: tb/axi_err_irq_reg_bench.sv
module axi_err_irq_reg_bench;
  logic clk = 0, rst_n = 0;
  logic reg_wr_en = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic b_valid = 0, b_ready = 0, r_valid = 0, r_ready = 0;
  logic [1:0] b_resp = 0, r_resp = 0;
  logic irq;

  int total = 0, bad = 0;
  string tag = "R10";
  logic [3:0] m_stat = 0, m_sen = 0, m_sig = 0;
  logic m_irq = 0;

  always #4 clk = ~clk;

  axi_err_irq_reg u_axi_err_irq_reg (.*);

  task automatic compare();
    logic [31:0] exp_rd;
    exp_rd = {12'b0, m_sig, 4'b0, m_sen, 4'b0, m_stat};
    total++;
    if (reg_rdata !== exp_rd || irq !== m_irq) begin
      bad++;
      $display("FAIL %s rdata=%h irq=%b expected rdata=%h irq=%b", tag, reg_rdata, irq, exp_rd, m_irq);
    end
  endtask

  task automatic step();
    logic [3:0] ev;
    @(posedge clk);
    ev = 0;
    if (b_valid && b_ready) begin
      if (b_resp == 2'b10) ev[3] = 1;
      if (b_resp == 2'b11) ev[2] = 1;
    end
    if (r_valid && r_ready) begin
      if (r_resp == 2'b10) ev[1] = 1;
      if (r_resp == 2'b11) ev[0] = 1;
    end
    m_irq = |(m_stat & m_sig);
    for (int i = 0; i < 4; i++) begin
      if (ev[i] && m_sen[i]) m_stat[i] = 1;
      else if (reg_wr_en && reg_wdata[i]) m_stat[i] = 0;
    end
    if (reg_wr_en) begin
      m_sen = reg_wdata[11:8];
      m_sig = reg_wdata[19:16];
    end
    @(negedge clk);
    compare();
  endtask

  task automatic drive(input logic bv, br, input logic [1:0] bc, input logic rv, rr,
                       input logic [1:0] rc, input logic we, input logic [31:0] wd);
    b_valid = bv; b_ready = br; b_resp = bc;
    r_valid = rv; r_ready = rr; r_resp = rc;
    reg_wr_en = we; reg_wdata = wd;
    step();
    b_valid = 0; r_valid = 0; reg_wr_en = 0;
  endtask

  task automatic idle(); drive(0,0,0,0,0,0,0,0); endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tag = "R10";
    repeat (3) @(negedge clk);
    compare();
    rst_n = 1;
    idle(); idle();
    tag = "R6";
    drive(0,0,0,0,0,0,1,32'hFFFF_FFFF);
    idle();
    drive(0,0,0,0,0,0,1,32'hABC5_A5A0);
    tag = "R2";
    drive(1,0,2'b10,1,0,2'b11,0,0);
    drive(0,1,2'b11,0,1,2'b10,0,0);
    tag = "R3";
    drive(1,1,2'b00,1,1,2'b01,0,0);
    drive(1,1,2'b01,1,1,2'b00,0,0);
    tag = "R4";
    drive(0,0,0,0,0,0,1,32'h0000_0000);
    drive(1,1,2'b10,1,1,2'b11,0,0);
    tag = "R1";
    drive(0,0,0,0,0,0,1,32'h0000_0F00);
    drive(1,1,2'b10,0,0,0,0,0);
    drive(1,1,2'b11,0,0,0,0,0);
    drive(0,0,0,1,1,2'b10,0,0);
    drive(0,0,0,1,1,2'b11,0,0);
    tag = "R5";
    drive(0,0,0,0,0,0,1,32'h0000_0F00);
    idle();
    drive(0,0,0,0,0,0,1,32'h0004_0F00);
    idle(); idle();
    tag = "R7";
    drive(0,0,0,0,0,0,1,32'h0004_0F00);
    drive(0,0,0,0,0,0,1,32'h0004_0F04);
    idle(); idle();
    tag = "R8";
    drive(1,1,2'b10,0,0,0,1,32'h000F_0F08);
    idle();
    drive(0,0,0,1,1,2'b11,1,32'h000F_0001);
    idle();
    tag = "R9";
    drive(0,0,0,0,0,0,1,32'h000F_0000);
    drive(1,1,2'b11,1,1,2'b10,0,0);
    idle();
    tag = "R1";
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] wd;
      wd = $urandom;
      wd[3:0] = ($urandom % 4 == 0) ? wd[3:0] : 4'b0;
      drive($urandom%2, $urandom%2, 2'($urandom), $urandom%2, $urandom%2, 2'($urandom),
            ($urandom % 8) == 0, wd);
    end
    tag = "R10";
    rst_n = 0;
    m_stat = 0; m_sen = 0; m_sig = 0; m_irq = 0;
    @(negedge clk);
    compare();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule